// File: doc/BRIEF.md
# Wait-State Bus Responder

This block sits in front of a peripheral register decoder and decides, for each access attempt on the register bus, whether the access goes through now or is answered with busy. A requester presents an attempt by holding `req_valid` high. Every cycle in which `req_valid` is high counts as one attempt. The block answers in the same cycle on `rsp_status`. When it lets an access through, it pulses `dec_fire` so that the decoder performs the access. It then forwards the decoder's hit or miss as ok or no-decode.

Real accesses pass through a two-state machine with the states idle and waiting, and a wait counter. The counter is loaded from the static input `cfg_waits` on the first attempt. It counts down by one on each later attempt, not on each clock. A configured count of N therefore gives N+1 busy answers, and the access completes on attempt N+2. Debug accesses (`req_real` low) skip the machine and complete at once, and they leave the state and the counter as they were.

The bus handshake is valid/ready. `req_ready` is high exactly when `req_valid` is high and the answer is not busy, and that is the cycle in which the access completes. A requester that sees `req_ready` low must present the same access again in a later cycle. It may drop `req_valid` for some cycles in between. Those cycles do not advance the wait count.

Top module: `wait_state_responder`

## Requirements
- R1: Reset forces the idle state and clears the counter: after reset, a real attempt with `cfg_waits` = 0 completes in its first cycle, even if reset arrived during a wait.
- R2: `rsp_status` uses the encoding 2'b00 ok, 2'b01 busy, 2'b10 no-decode. When an access completes, the status is ok if `dec_hit` is 1 and no-decode if `dec_hit` is 0.
- R3: In idle with `cfg_waits` = 0, a real attempt completes in the same cycle: `dec_fire` = 1 and the decoder's status is returned.
- R4: In idle with `cfg_waits` = N > 0, a real attempt returns busy with `dec_fire` = 0, loads the counter with N and moves to waiting.
- R5: In waiting with the counter nonzero, a real attempt returns busy and decrements the counter. With N configured, exactly N+1 busy answers precede completion, including N = 15.
- R6: In waiting with the counter at zero, a real attempt completes and the state returns to idle, so the next real attempt starts a fresh count.
- R7: A debug attempt (`req_real` = 0) completes in its own cycle in either state, and it changes neither the state nor the counter.
- R8: A cycle with `req_valid` low gives `rsp_status` = ok, `dec_fire` = 0 and `req_ready` = 0, and it changes neither the state nor the counter.
- R9: A change of `cfg_waits` while waiting does not change the count already in progress.
- R10: `req_ready` equals `dec_fire`, and it is 1 exactly when `req_valid` is 1 and the status is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_waits | input | 4 | Configured number of wait attempts (static) |
| req_valid | input | 1 | An access attempt is presented this cycle |
| req_real | input | 1 | 1 = real access, 0 = debug access |
| req_ready | output | 1 | Access accepted and completed this cycle |
| rsp_status | output | 2 | Response: 00 ok, 01 busy, 10 no-decode |
| dec_fire | output | 1 | Strobe telling the decoder to perform the access |
| dec_hit | input | 1 | Decoder result: 1 = address decoded, 0 = not decoded |

## Verification
The bench builds the block with its default 4-bit wait width. That puts the largest count, 15, within reach: it runs a full 16-busy sequence to completion, and the check counts every busy answer. With this width the bench also changes the configured count in the middle of a wait, mixes debug attempts and idle cycles into a wait, and applies a reset partway through a count. In every case the result shows at the ports.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    RSP_OK    = 2'b00,
    RSP_BUSY  = 2'b01,
    RSP_NODEC = 2'b10
  } rsp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wsr_state_e;
endpackage

// File: rtl/wsr_wait_counter.sv
module wsr_wait_counter #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [WAIT_W-1:0] load_val,
  output logic [WAIT_W-1:0] count,
  output logic              at_zero
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count - ONE;
  end

  assign at_zero = (count == '0);

  // R4: a load captures the configured value
  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R5: each busy attempt in waiting takes exactly one off the count
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == $past(count) - ONE);
  // R8: without a load or a step the count holds
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count));
  // R5: stepping never starts from zero
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_zero);
endmodule

// File: rtl/wsr_fsm.sv
module wsr_fsm
  import wsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_real,
  input  logic       cfg_zero,
  input  logic       cnt_zero,
  output wsr_state_e state,
  output logic       load,
  output logic       step,
  output logic       pass_real
);
  logic real_req;
  logic in_idle;
  wsr_state_e state_nx;

  assign real_req  = req_valid && req_real;
  assign in_idle   = (state == ST_IDLE);
  assign load      = real_req && in_idle && !cfg_zero;
  assign step      = real_req && !in_idle && !cnt_zero;
  assign pass_real = real_req && (in_idle ? cfg_zero : cnt_zero);

  always_comb begin
    state_nx = state;
    if (real_req) begin
      unique case (state)
        ST_IDLE: if (!cfg_zero) state_nx = ST_WAIT;
        ST_WAIT: if (cnt_zero)  state_nx = ST_IDLE;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R6: a completed wait returns to idle
  assert_wait_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && real_req && cnt_zero) |=> state == ST_IDLE);
  // R4: a nonzero count in idle enters waiting
  assert_wait_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && real_req && !cfg_zero) |=> state == ST_WAIT);
  // R7/R8: attempts that are not real leave the state alone
  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !real_req |=> $stable(state));
endmodule

// File: rtl/wsr_status_mux.sv
module wsr_status_mux
  import wsr_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_real,
  input  logic       pass_real,
  input  logic       hold_off,
  input  logic       dec_hit,
  output logic       fire,
  output rsp_e       status
);
  assign fire = req_valid && (!req_real || pass_real);

  always_comb begin
    if (!req_valid)    status = RSP_OK;
    else if (fire)     status = dec_hit ? RSP_OK : RSP_NODEC;
    else               status = RSP_BUSY;
  end

  // R10: a held-off real attempt is never also a completion
  always_comb begin
    if (req_valid && req_real && hold_off)
      assert_hold_no_fire_R10: assert (!fire);
  end
endmodule

// File: rtl/wait_state_responder.sv
module wait_state_responder
  import wsr_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              req_valid,
  input  logic              req_real,
  output logic              req_ready,
  output logic [1:0]        rsp_status,
  output logic              dec_fire,
  input  logic              dec_hit
);
  wsr_state_e        state;
  logic              load, step, pass_real;
  logic [WAIT_W-1:0] count;
  logic              cnt_zero;
  logic              cfg_zero;
  rsp_e              status;

  assign cfg_zero = (cfg_waits == '0);

  wsr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_real  (req_real),
    .cfg_zero  (cfg_zero),
    .cnt_zero  (cnt_zero),
    .state     (state),
    .load      (load),
    .step      (step),
    .pass_real (pass_real)
  );

  wsr_wait_counter #(.WAIT_W(WAIT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .load_val (cfg_waits),
    .count    (count),
    .at_zero  (cnt_zero)
  );

  wsr_status_mux u_mux (
    .req_valid (req_valid),
    .req_real  (req_real),
    .pass_real (pass_real),
    .hold_off  (load || step),
    .dec_hit   (dec_hit),
    .fire      (dec_fire),
    .status    (status)
  );

  assign rsp_status = status;
  assign req_ready  = dec_fire;

  // R10: busy answers never carry ready
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_status == RSP_BUSY) |-> (!req_ready && req_valid));
  // R7: a debug attempt always completes at once
  assert_debug_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_real) |-> dec_fire);
  // R7: a debug attempt leaves the count untouched
  assert_debug_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_real) |=> $stable(count));
  // R2: no reserved status code ever appears
  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status != 2'b11);
  // R9: while waiting, the count does not follow the configuration
  assert_cfg_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !step && !load) |=> $stable(count));
endmodule

// File: tb/tb_wait_state_responder.sv
module tb_wait_state_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_waits = 4'd0;
  logic       req_valid = 1'b0;
  logic       req_real = 1'b1;
  logic       dec_hit = 1'b1;
  logic       req_ready;
  logic [1:0] rsp_status;
  logic       dec_fire;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wait_state_responder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_waits  (cfg_waits),
    .req_valid  (req_valid),
    .req_real   (req_real),
    .req_ready  (req_ready),
    .rsp_status (rsp_status),
    .dec_fire   (dec_fire),
    .dec_hit    (dec_hit)
  );

  // entry: [9:6] cfg, [5] valid, [4] real, [3] hit, [2:1] expected status, [0] expected fire
  localparam logic [9:0] VEC [12] = '{
    10'b0000_1_1_1_00_1,  // R3 zero wait completes at once
    10'b0000_1_1_0_10_1,  // R2 miss forwarded as no-decode
    10'b0010_1_1_1_01_0,  // R4 first attempt busy, load 2
    10'b0010_0_1_1_00_0,  // R8 idle cycle
    10'b0010_1_1_1_01_0,  // R5 2 -> 1
    10'b0010_1_0_0_10_1,  // R7 debug bypass mid-wait
    10'b0010_1_1_1_01_0,  // R5 1 -> 0
    10'b0010_1_1_1_00_1,  // R6 complete, back to idle
    10'b0001_1_1_1_01_0,  // R4 load 1
    10'b0111_1_1_1_01_0,  // R9 cfg change ignored, 1 -> 0
    10'b0111_1_1_0_10_1,  // R9 completes on old count
    10'b0000_1_1_1_00_1   // R6 idle again
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      3: return "R8";
      4: return "R5";
      5: return "R7";
      6: return "R5";
      7: return "R6";
      8: return "R4";
      9: return "R9";
      10: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, sample a little later, before the next rising edge
  task automatic attempt(logic [3:0] c, logic v, logic r, logic h);
    @(negedge clk);
    cfg_waits = c;
    req_valid = v;
    req_real  = r;
    dec_hit   = h;
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int busy_seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R8: reset state with no request
    attempt(4'd0, 1'b0, 1'b1, 1'b1);
    check("R8", "status idle", rsp_status, 0);
    check("R8", "fire idle", dec_fire, 0);
    check("R1", "ready idle", req_ready, 0);

    for (int i = 0; i < 12; i++) begin
      logic [9:0] e;
      e = VEC[i];
      attempt(e[9:6], e[5], e[4], e[3]);
      check(vec_tag(i), "status", rsp_status, e[2:1]);
      check(vec_tag(i), "fire", dec_fire, e[0]);
      check("R10", "ready", req_ready, (e[5] && e[2:1] != 2'b01) ? 1 : 0);
    end

    // R5: largest count gives 16 busy answers then completion
    busy_seen = 0;
    for (int k = 0; k < 20; k++) begin
      attempt(4'd15, 1'b1, 1'b1, 1'b1);
      if (rsp_status == 2'b01) busy_seen++;
      else break;
    end
    check("R5", "busy count at 15", busy_seen, 16);
    check("R5", "final status", rsp_status, 0);
    check("R5", "final fire", dec_fire, 1);

    // R7: debug in idle with nonzero cfg completes and does not start a wait
    attempt(4'd1, 1'b1, 1'b0, 1'b1);
    check("R7", "debug fire in idle", dec_fire, 1);
    attempt(4'd1, 1'b1, 1'b1, 1'b1);
    check("R7", "real after debug busy", rsp_status, 1);
    attempt(4'd1, 1'b1, 1'b1, 1'b1);
    check("R7", "count still 1 step", rsp_status, 1);
    attempt(4'd1, 1'b1, 1'b1, 1'b1);
    check("R7", "completes after 2 busy", dec_fire, 1);

    // R1: reset during a wait returns to idle
    attempt(4'd3, 1'b1, 1'b1, 1'b1);
    check("R1", "busy before reset", rsp_status, 1);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    attempt(4'd0, 1'b1, 1'b1, 1'b0);
    check("R1", "fire after reset", dec_fire, 1);
    check("R1", "status after reset", rsp_status, 2);

    attempt(4'd0, 1'b0, 1'b1, 1'b1);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule